// File: doc/BRIEF.md
# Segment Access Rights Checker

This block judges each memory reference against the descriptor already cached for its segment. Each request carries the descriptor's 8-bit rights byte, its 20-bit limit, a granularity flag, the current privilege level, the reference offset and the kind of access: read, write or execute. The block decides whether the reference is allowed. If it is not, the block reports one 3-bit fault cause. The block does not add the segment base, handle paging, load descriptors or interpret system and gate descriptors.

Data and code descriptors follow different rules. Data segments may grow upward or downward, and they may be read-only. Code segments may be execute-only. Execution of a code segment also depends on the privilege rule that the conforming bit selects.

The verdict is computed combinationally and then held in a small response state machine for one cycle. The machine has three states:
- `ST_IDLE` means no response this cycle.
- `ST_PASS` means the previous request was allowed.
- `ST_FAULT` means the previous request faulted.

Every state moves on each clock by the same rules:
- With no request it goes to `ST_IDLE` (transition *drop*).
- With a request that passes it goes to `ST_PASS` (transition *grant*).
- With a request that faults it goes to `ST_FAULT` (transition *deny*).

Reset enters `ST_IDLE`.

Top module: `seg_access_checker`

## Requirements
- R1: While reset is held and right after it, `rsp_valid`, `rsp_ok` and `rsp_cause` are all 0.
- R2: A request sampled at a rising edge produces its response right after that edge, and the response lasts one cycle. A cycle with no request gives `rsp_valid`=0 and cause 0 after the next edge. Back-to-back requests give back-to-back responses.
- R3: If rights bit 7 (present) is 0, the cause is 1 (not present), whatever the other bits are.
- R4: If the segment is present and rights bit 4 is 0, the descriptor is a system or gate descriptor and the cause is 2.
- R5: An execute request against a data segment faults with cause 6. A data segment has rights bit 3 (executable) equal to 0.
- R6: A write request faults with cause 4 in two cases: against any code segment (bit 3 = 1), and against a data segment whose bit 1 (writable) is 0.
- R7: A read request against a code segment whose bit 1 (readable) is 0 faults with cause 5. A read of a data segment is always permitted by type.
- R8: Execution of a code segment is checked against the DPL in rights bits 6..5:
  - If bit 2 (conforming) is 1, it needs CPL >= DPL.
  - If bit 2 is 0, it needs CPL == DPL.
  - Otherwise the cause is 7.
  - Reads and writes do no privilege test.
- R9: When the granularity flag is 0, the effective limit is the 20-bit limit. When it is 1, the effective limit is the limit shifted left by 12 with the low 12 bits set to ones.
- R10: Data segments with bit 2 = 1 grow downward and need offset > effective limit. All other segments need offset <= effective limit. A violation gives cause 3.
- R11: When several faults apply, the reported cause is the first in this order: 1, 2, 6, 4, 5, 7, 3. `rsp_ok` is 1 exactly when a response has cause 0.
- R12: Access kind is encoded as 00 read, 01 write, 10 execute, and 11 is treated as read. Rights bit 0 (accessed) has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A reference is presented this cycle |
| req_rights | input | 8 | Cached descriptor rights byte |
| req_limit | input | 20 | Cached descriptor limit |
| req_gran | input | 1 | Limit unit: 0 bytes, 1 4-KiB pages |
| req_cpl | input | 2 | Current privilege level |
| req_kind | input | 2 | Access kind (00 read, 01 write, 10 execute, 11 read) |
| req_offset | input | 32 | Reference offset within the segment |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Reference allowed |
| rsp_cause | output | 3 | Fault cause, 0 when allowed or idle |

## Verification
The permission decode and the limit comparator work on the same request in the same cycle, so a single reference can be both out of range and forbidden by type or privilege. The bench provokes this in two ways. Directed cases write a read-only data segment past its limit and read an execute-only code segment past its limit. Random traffic also places offsets right at and around the effective limit under every rights pattern. A behavioural reference model compares every cycle and judges that the cause follows the priority order. The limit fault may appear only when every type and privilege test passes.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_ALT   = 2'b11
    } acc_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE        = 3'd0,
        CAUSE_NOT_PRESENT = 3'd1,
        CAUSE_SYSTEM      = 3'd2,
        CAUSE_LIMIT       = 3'd3,
        CAUSE_WPROT       = 3'd4,
        CAUSE_RPROT       = 3'd5,
        CAUSE_EXEC_DATA   = 3'd6,
        CAUSE_PRIV        = 3'd7
    } fault_e;

    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic       code_or_data;
        logic       exec;
        logic       dir_or_conf;
        logic       wr_or_rd;
        logic       touched;
    } rights_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_FAULT = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int OFF_W      = 32
) (
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic               gran_i,
    input  logic               down_i,
    input  logic [OFF_W-1:0]   offset_i,
    output logic               in_range_o
);
    localparam int EFF_W = LIMIT_W + PAGE_SHIFT;
    localparam int CMP_W = (OFF_W > EFF_W) ? OFF_W : EFF_W;

    logic [EFF_W-1:0] eff_lim;
    logic [CMP_W-1:0] off_x;
    logic [CMP_W-1:0] lim_x;

    always_comb begin
        if (gran_i) begin
            eff_lim = {limit_i, {PAGE_SHIFT{1'b1}}};
        end else begin
            eff_lim = EFF_W'(limit_i);
        end
        off_x = CMP_W'(offset_i);
        lim_x = CMP_W'(eff_lim);
    end

    always_comb begin
        if (down_i) begin
            in_range_o = (off_x > lim_x);
        end else begin
            in_range_o = (off_x <= lim_x);
        end
    end

endmodule

// File: rtl/seg_rights_decode.sv
module seg_rights_decode
    import seg_chk_pkg::*;
(
    input  rights_t    rights_i,
    input  acc_kind_e  kind_i,
    input  logic [1:0] cpl_i,
    input  logic       in_range_i,
    output logic       down_o,
    output fault_e     cause_o
);
    logic is_code;
    logic want_wr;
    logic want_ex;
    logic priv_ok;

    always_comb begin
        is_code = rights_i.exec;
        want_wr = (kind_i == ACC_WRITE);
        want_ex = (kind_i == ACC_EXEC);
        down_o  = ~rights_i.exec & rights_i.dir_or_conf;
        if (rights_i.dir_or_conf) begin
            priv_ok = (cpl_i >= rights_i.dpl);
        end else begin
            priv_ok = (cpl_i == rights_i.dpl);
        end
    end

    always_comb begin
        if (!rights_i.present) begin
            cause_o = CAUSE_NOT_PRESENT;
        end else if (!rights_i.code_or_data) begin
            cause_o = CAUSE_SYSTEM;
        end else if (want_ex && !is_code) begin
            cause_o = CAUSE_EXEC_DATA;
        end else if (want_wr && (is_code || !rights_i.wr_or_rd)) begin
            cause_o = CAUSE_WPROT;
        end else if (!want_wr && !want_ex && is_code && !rights_i.wr_or_rd) begin
            cause_o = CAUSE_RPROT;
        end else if (want_ex && !priv_ok) begin
            cause_o = CAUSE_PRIV;
        end else if (!in_range_i) begin
            cause_o = CAUSE_LIMIT;
        end else begin
            cause_o = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int OFF_W      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [7:0]         req_rights,
    input  logic [LIMIT_W-1:0] req_limit,
    input  logic               req_gran,
    input  logic [1:0]         req_cpl,
    input  logic [1:0]         req_kind,
    input  logic [OFF_W-1:0]   req_offset,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [2:0]         rsp_cause
);
    rights_t    rts;
    acc_kind_e  kind;
    logic       down;
    logic       in_range;
    fault_e     cause_d;
    fault_e     cause_q;
    rsp_state_e state_q;
    rsp_state_e state_d;

    assign rts  = rights_t'(req_rights);
    assign kind = acc_kind_e'(req_kind);

    seg_rights_decode u_decode (
        .rights_i   (rts),
        .kind_i     (kind),
        .cpl_i      (req_cpl),
        .in_range_i (in_range),
        .down_o     (down),
        .cause_o    (cause_d)
    );

    seg_limit_unit #(
        .LIMIT_W    (LIMIT_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .OFF_W      (OFF_W)
    ) u_limit (
        .limit_i    (req_limit),
        .gran_i     (req_gran),
        .down_i     (down),
        .offset_i   (req_offset),
        .in_range_o (in_range)
    );

    // next-state: drop / grant / deny
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_FAULT: begin
                if (!req_valid) begin
                    state_d = ST_IDLE;
                end else if (cause_d == CAUSE_NONE) begin
                    state_d = ST_PASS;
                end else begin
                    state_d = ST_FAULT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= req_valid ? cause_d : CAUSE_NONE;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_ok    = 1'b0;
        rsp_cause = 3'd0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_PASS: begin
                rsp_valid = 1'b1;
                rsp_ok    = 1'b1;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_cause = cause_q;
            end
            default: rsp_valid = 1'b0;
        endcase
    end

    a_r2_idle_no_response: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_cause == 3'd0));

    a_r3_not_present: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_rights[7]) |=> (rsp_valid && !rsp_ok && rsp_cause == 3'd1));

    a_r4_system_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rights[7] && !req_rights[4]) |=> (rsp_cause == 3'd2));

    a_r6_code_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rights[7] && req_rights[4] && req_rights[3] && req_kind == 2'b01)
        |=> (rsp_cause == 3'd4));

    a_r11_ok_means_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok == (rsp_cause == 3'd0)));

endmodule

// File: tb/tb_seg_access_checker.sv
module tb_seg_access_checker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [7:0]  req_rights;
    logic [19:0] req_limit;
    logic        req_gran;
    logic [1:0]  req_cpl;
    logic [1:0]  req_kind;
    logic [31:0] req_offset;
    logic        rsp_valid;
    logic        rsp_ok;
    logic [2:0]  rsp_cause;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    seg_access_checker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rights(req_rights),
        .req_limit(req_limit), .req_gran(req_gran), .req_cpl(req_cpl),
        .req_kind(req_kind), .req_offset(req_offset), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_cause(rsp_cause)
    );

    function automatic int model_cause(logic [7:0] r, logic [19:0] lim, logic g,
                                       logic [1:0] cpl, logic [1:0] k, logic [31:0] off);
        longint eff;
        longint o;
        int dpl;
        bit code, rd, wr, ex, ok_range, ok_priv;
        dpl  = int'(r[6:5]);
        code = r[3];
        wr   = (k == 2'b01);
        ex   = (k == 2'b10);
        rd   = !wr && !ex;
        eff  = g ? (longint'(lim) * 4096 + 4095) : longint'(lim);
        o    = longint'(off);
        if (!code && r[2]) ok_range = (o > eff);
        else               ok_range = (o <= eff);
        if (r[2]) ok_priv = (int'(cpl) >= dpl);
        else      ok_priv = (int'(cpl) == dpl);
        if (!r[7])                    return 1;
        if (!r[4])                    return 2;
        if (ex && !code)              return 6;
        if (wr && (code || !r[1]))    return 4;
        if (rd && code && !r[1])      return 5;
        if (ex && !ok_priv)           return 7;
        if (!ok_range)                return 3;
        return 0;
    endfunction

    task automatic compare_front();
        logic [4:0] e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rsp_valid !== e[4] || rsp_ok !== e[3] || rsp_cause !== e[2:0]) begin
            n_fail++;
            $display("FAIL %s: got valid=%b ok=%b cause=%0d, expected valid=%b ok=%b cause=%0d",
                     t, rsp_valid, rsp_ok, rsp_cause, e[4], e[3], e[2:0]);
        end
    endtask

    task automatic issue(bit v, logic [7:0] r, logic [19:0] lim, logic g,
                         logic [1:0] cpl, logic [1:0] k, logic [31:0] off, string t);
        int c;
        @(negedge clk);
        compare_front();
        req_valid  = v;
        req_rights = r;
        req_limit  = lim;
        req_gran   = g;
        req_cpl    = cpl;
        req_kind   = k;
        req_offset = off;
        c = model_cause(r, lim, g, cpl, k, off);
        if (!v) exp_q.push_back(5'b0_0_000);
        else    exp_q.push_back({1'b1, (c == 0), 3'(c)});
        tag_q.push_back(t);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 0; req_rights = 0; req_limit = 0;
        req_gran = 0; req_cpl = 0; req_kind = 0; req_offset = 0;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (rsp_valid !== 0 || rsp_ok !== 0 || rsp_cause !== 0) begin
            n_fail++;
            $display("FAIL R1: got %b%b%0d expected 000 in reset", rsp_valid, rsp_ok, rsp_cause);
        end
        rst_n = 1'b1;
        exp_q.push_back(5'b0); tag_q.push_back("R1");
        // R3 not present, including system-typed
        issue(1, 8'h13, 20'hFFFFF, 0, 0, 2'b00, 0, "R3");
        issue(1, 8'h00, 20'hFFFFF, 0, 0, 2'b10, 0, "R3");
        // R4 system descriptor
        issue(1, 8'h82, 20'hFFFFF, 0, 0, 2'b00, 0, "R4");
        // R5 execute on data
        issue(1, 8'h92, 20'hFFFFF, 0, 0, 2'b10, 0, "R5");
        // R6 write protection
        issue(1, 8'h90, 20'hFFFFF, 0, 0, 2'b01, 5, "R6");
        issue(1, 8'h9A, 20'hFFFFF, 0, 0, 2'b01, 5, "R6");
        issue(1, 8'h92, 20'hFFFFF, 0, 0, 2'b01, 5, "R6");
        // R7 read protection
        issue(1, 8'h98, 20'hFFFFF, 0, 0, 2'b00, 5, "R7");
        issue(1, 8'h9A, 20'hFFFFF, 0, 0, 2'b00, 5, "R7");
        // R8 privilege
        issue(1, 8'hBA, 20'hFFFFF, 0, 1, 2'b10, 0, "R8");
        issue(1, 8'hBA, 20'hFFFFF, 0, 2, 2'b10, 0, "R8");
        issue(1, 8'hBE, 20'hFFFFF, 0, 2, 2'b10, 0, "R8");
        issue(1, 8'hBE, 20'hFFFFF, 0, 0, 2'b10, 0, "R8");
        issue(1, 8'hBA, 20'hFFFFF, 0, 3, 2'b00, 0, "R8");
        // R9 granularity
        issue(1, 8'h92, 20'h00001, 1, 0, 2'b00, 32'h1FFF, "R9");
        issue(1, 8'h92, 20'h00001, 1, 0, 2'b00, 32'h2000, "R9");
        issue(1, 8'h92, 20'hFFFFF, 0, 0, 2'b00, 32'hFFFFF, "R9");
        issue(1, 8'h92, 20'hFFFFF, 0, 0, 2'b00, 32'h100000, "R9");
        issue(1, 8'h92, 20'hFFFFF, 1, 0, 2'b01, 32'hFFFFFFFF, "R9");
        // R10 expand-down
        issue(1, 8'h96, 20'h00010, 0, 0, 2'b00, 32'h10, "R10");
        issue(1, 8'h96, 20'h00010, 0, 0, 2'b01, 32'h11, "R10");
        issue(1, 8'h9E, 20'h00010, 0, 0, 2'b10, 32'h11, "R10");
        // R11 same-cycle priority
        issue(1, 8'h90, 20'h00010, 0, 0, 2'b01, 32'h40, "R11");
        issue(1, 8'h98, 20'h00010, 0, 0, 2'b00, 32'h40, "R11");
        issue(1, 8'hBA, 20'h00010, 0, 0, 2'b10, 32'h40, "R11");
        // R12 encoding and accessed bit
        issue(1, 8'h98, 20'hFFFFF, 0, 0, 2'b11, 0, "R12");
        issue(1, 8'h93, 20'h00010, 0, 0, 2'b01, 32'h10, "R12");
        issue(1, 8'h92, 20'h00010, 0, 0, 2'b01, 32'h10, "R12");
        // R2 idle gaps
        issue(0, 8'h00, 0, 0, 0, 0, 0, "R2");
        issue(1, 8'h92, 20'h10, 0, 0, 0, 0, "R2");
        issue(0, 8'h13, 0, 0, 0, 0, 0, "R2");
        // random traffic, offsets near the limit
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  r;
            logic [19:0] lim;
            logic        g;
            logic [31:0] off;
            longint      eff;
            r   = 8'($urandom);
            if ($urandom_range(3) != 0) r = r | 8'h90;
            lim = 20'($urandom_range(4095));
            g   = 1'($urandom);
            eff = g ? (longint'(lim) * 4096 + 4095) : longint'(lim);
            case ($urandom_range(2))
                0: off = 32'(eff);
                1: off = 32'(eff + 1);
                default: off = 32'($urandom);
            endcase
            issue(1'($urandom_range(7) != 0), r, lim, g, 2'($urandom), 2'($urandom), off, "R11");
        end
        issue(0, 0, 0, 0, 0, 0, 0, "R2");
        @(negedge clk);
        compare_front();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule